// File: doc/BRIEF.md
# Clock Divider Setting Search Engine

This block turns a requested clock frequency, given as an integer number of kHz, into a set of divider values for a clock synthesizer running from a 25 MHz reference. After a start pulse it walks a fixed, ordered list of reference and post divider combinations, one combination per clock cycle. For each combination it computes the rounded feedback divider, checks that it lies in the legal window and that the resulting frequency is close enough to the request, and stops at the first combination that passes.

The chosen settings come out as separate fields and as one packed 32-bit register image: a control byte, the feedback divider, the reference divider and a byte that holds both post dividers. The control byte also flags when the oscillator stage runs at or above 2.4 GHz. When no combination passes, the block reports failure and outputs a fixed default setting for 200 MHz. A host raises start, waits for the one-cycle done pulse and then reads the held outputs.

Top module: `pll_div_search`

## Requirements
- R1: A start pulse seen while idle makes busy_o high in the next cycle; start pulses seen while busy do not change the search or its result.
- R2: Combinations are tried one per cycle in this order: reference divider 2, then 1; inside each, post divider 1 from 7 down to 2; inside that, post divider 2 from 1 upward while below post divider 1. A hit on the k-th combination raises done_o k cycles after the start edge.
- R3: With m = ref × pd1 × pd2 and t the target in kHz, the feedback divider is floor((m·t + 12500) / 25000).
- R4: A combination is taken only if its feedback divider is in 144..235 inclusive and |m·t − 25000·fb| < 10000·m (error below 10 MHz); the first such combination ends the search with found_o = 1.
- R5: freq_khz_o equals floor(25000·fb / m) for the chosen combination.
- R6: image_o[31:24] is the control byte, [23:16] the feedback divider, [15:8] the reference divider, [7:4] pd1 − 1 and [3:0] pd2 − 1.
- R7: The control byte and high_vco_o are 0x50 and 1 when 25000·fb ≥ 2400000·ref, otherwise 0x40 and 0.
- R8: When no combination passes, done_o rises 42 cycles after start with found_o = 0, image_o = 0x40A00241, fb 160, ref 2, pd1 5, pd2 2 and freq_khz_o = 200000.
- R9: done_o is a single-cycle pulse with busy_o low in that cycle, and all result outputs hold their values until the next result is written.
- R10: After reset busy_o, done_o and found_o are 0 and the result outputs show the default 200 MHz setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a search (taken only while idle) |
| target_khz_i | input | 22 | Requested frequency in kHz |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse when a result is written |
| found_o | output | 1 | 1 if a combination passed, 0 if default used |
| fbdiv_o | output | 8 | Feedback divider |
| refdiv_o | output | 2 | Reference divider |
| postdiv1_o | output | 3 | Post divider 1 |
| postdiv2_o | output | 3 | Post divider 2 |
| freq_khz_o | output | 22 | Achieved frequency in kHz |
| high_vco_o | output | 1 | Oscillator at or above 2.4 GHz |
| image_o | output | 32 | Packed register image |

## Verification
busy_o is due one cycle after the start edge, and done_o with every result field is due exactly k cycles after it, where k is the position of the first passing combination in the search order, or 42 when none passes. The bench computes k and all expected fields arithmetically for each target, counts clock edges from the start edge and requires done_o at precisely that count, sampling on the falling edge. It then checks one cycle later that done_o has dropped and the fields are unchanged, and it injects a second start mid-search to show the running search is unaffected.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
  typedef enum logic [0:0] {ST_IDLE, ST_RUN} state_e;

  localparam logic [7:0] CTRL_LO      = 8'h40;
  localparam logic [7:0] CTRL_HI      = 8'h50;
  localparam int         DEF_FB       = 160;
  localparam int         DEF_REF      = 2;
  localparam int         DEF_PD1      = 5;
  localparam int         DEF_PD2      = 2;
  localparam int         DEF_FREQ_KHZ = 200000;
endpackage

// File: rtl/pll_seq.sv
module pll_seq #(
  parameter int REF_MAX = 2,
  parameter int PD_MAX  = 7,
  parameter int REF_W   = 2,
  parameter int PD_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             adv_i,
  output logic [REF_W-1:0] ref_o,
  output logic [PD_W-1:0]  pd1_o,
  output logic [PD_W-1:0]  pd2_o,
  output logic             last_o
);
  logic [REF_W-1:0] ref_q;
  logic [PD_W-1:0]  pd1_q, pd2_q;
  logic             pd2_wrap, pd1_wrap;

  // pd2 runs 1..pd1-1, pd1 runs PD_MAX..2, ref runs REF_MAX..1
  assign pd2_wrap = (pd2_q + PD_W'(1)) >= pd1_q;
  assign pd1_wrap = pd1_q == PD_W'(2);
  assign last_o   = pd2_wrap && pd1_wrap && (ref_q == REF_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= REF_W'(REF_MAX);
      pd1_q <= PD_W'(PD_MAX);
      pd2_q <= PD_W'(1);
    end else if (init_i) begin
      ref_q <= REF_W'(REF_MAX);
      pd1_q <= PD_W'(PD_MAX);
      pd2_q <= PD_W'(1);
    end else if (adv_i && !last_o) begin
      if (!pd2_wrap) begin
        pd2_q <= pd2_q + PD_W'(1);
      end else if (!pd1_wrap) begin
        pd1_q <= pd1_q - PD_W'(1);
        pd2_q <= PD_W'(1);
      end else begin
        ref_q <= ref_q - REF_W'(1);
        pd1_q <= PD_W'(PD_MAX);
        pd2_q <= PD_W'(1);
      end
    end
  end

  assign ref_o = ref_q;
  assign pd1_o = pd1_q;
  assign pd2_o = pd2_q;
endmodule

// File: rtl/pll_eval.sv
module pll_eval #(
  parameter int TGT_W   = 22,
  parameter int REF_W   = 2,
  parameter int PD_W    = 3,
  parameter int M_W     = 7,
  parameter int REF_KHZ = 25000,
  parameter int FB_MIN  = 144,
  parameter int FB_MAX  = 235,
  parameter int TOL_KHZ = 10000,
  parameter int VCO_KHZ = 2400000
) (
  input  logic [TGT_W-1:0] target_i,
  input  logic [REF_W-1:0] ref_i,
  input  logic [PD_W-1:0]  pd1_i,
  input  logic [PD_W-1:0]  pd2_i,
  output logic             hit_o,
  output logic [7:0]       fb_o,
  output logic [TGT_W-1:0] freq_o,
  output logic             hi_vco_o
);
  localparam int NUM_W = TGT_W + M_W + 2;

  logic [NUM_W-1:0] m_w, num, fb_full, prod, abs_err, tol, freq_full;
  logic             in_rng;

  always_comb begin
    m_w      = NUM_W'(ref_i) * NUM_W'(pd1_i) * NUM_W'(pd2_i);
    num      = m_w * NUM_W'(target_i);
    fb_full  = (num + NUM_W'(REF_KHZ / 2)) / NUM_W'(REF_KHZ);
    prod     = fb_full * NUM_W'(REF_KHZ);
    abs_err  = (num >= prod) ? (num - prod) : (prod - num);
    tol      = m_w * NUM_W'(TOL_KHZ);
    in_rng   = (fb_full >= NUM_W'(FB_MIN)) && (fb_full <= NUM_W'(FB_MAX));
    freq_full = (m_w == '0) ? '0 : prod / m_w;
    hit_o    = in_rng && (abs_err < tol);
    fb_o     = 8'(fb_full);
    freq_o   = TGT_W'(freq_full);
    hi_vco_o = prod >= (NUM_W'(VCO_KHZ) * NUM_W'(ref_i));
  end
endmodule

// File: rtl/pll_pack.sv
module pll_pack
  import pll_search_pkg::*;
#(
  parameter int REF_W = 2,
  parameter int PD_W  = 3
) (
  input  logic [7:0]       fb_i,
  input  logic [REF_W-1:0] ref_i,
  input  logic [PD_W-1:0]  pd1_i,
  input  logic [PD_W-1:0]  pd2_i,
  input  logic             hi_i,
  output logic [31:0]      image_o
);
  logic [3:0] pd1_m1, pd2_m1;

  assign pd1_m1  = 4'(pd1_i) - 4'd1;
  assign pd2_m1  = 4'(pd2_i) - 4'd1;
  assign image_o = {hi_i ? CTRL_HI : CTRL_LO, fb_i, 8'(ref_i), pd1_m1, pd2_m1};
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pll_search_pkg::*;
#(
  parameter int TGT_W   = 22,
  parameter int REF_MAX = 2,
  parameter int PD_MAX  = 7,
  parameter int REF_KHZ = 25000,
  parameter int FB_MIN  = 144,
  parameter int FB_MAX  = 235,
  parameter int TOL_KHZ = 10000,
  parameter int VCO_KHZ = 2400000,
  localparam int REF_W  = $clog2(REF_MAX + 1),
  localparam int PD_W   = $clog2(PD_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TGT_W-1:0] target_khz_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             found_o,
  output logic [7:0]       fbdiv_o,
  output logic [REF_W-1:0] refdiv_o,
  output logic [PD_W-1:0]  postdiv1_o,
  output logic [PD_W-1:0]  postdiv2_o,
  output logic [TGT_W-1:0] freq_khz_o,
  output logic             high_vco_o,
  output logic [31:0]      image_o
);
  localparam int M_W = $clog2(REF_MAX * PD_MAX * PD_MAX + 1);

  state_e           state_q;
  logic [TGT_W-1:0] tgt_q;
  logic             done_q, found_q, hi_q;
  logic [7:0]       fb_q;
  logic [REF_W-1:0] ref_q;
  logic [PD_W-1:0]  pd1_q, pd2_q;
  logic [TGT_W-1:0] freq_q;

  logic             launch, running;
  logic [REF_W-1:0] c_ref;
  logic [PD_W-1:0]  c_pd1, c_pd2;
  logic             c_last, c_hit, c_hi;
  logic [7:0]       c_fb;
  logic [TGT_W-1:0] c_freq;

  assign launch  = start_i && (state_q == ST_IDLE);
  assign running = state_q == ST_RUN;

  pll_seq #(
    .REF_MAX(REF_MAX), .PD_MAX(PD_MAX), .REF_W(REF_W), .PD_W(PD_W)
  ) u_seq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .init_i(launch),
    .adv_i (running),
    .ref_o (c_ref),
    .pd1_o (c_pd1),
    .pd2_o (c_pd2),
    .last_o(c_last)
  );

  pll_eval #(
    .TGT_W(TGT_W), .REF_W(REF_W), .PD_W(PD_W), .M_W(M_W),
    .REF_KHZ(REF_KHZ), .FB_MIN(FB_MIN), .FB_MAX(FB_MAX),
    .TOL_KHZ(TOL_KHZ), .VCO_KHZ(VCO_KHZ)
  ) u_eval (
    .target_i(tgt_q),
    .ref_i   (c_ref),
    .pd1_i   (c_pd1),
    .pd2_i   (c_pd2),
    .hit_o   (c_hit),
    .fb_o    (c_fb),
    .freq_o  (c_freq),
    .hi_vco_o(c_hi)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tgt_q   <= '0;
      done_q  <= 1'b0;
      found_q <= 1'b0;
      hi_q    <= 1'b0;
      fb_q    <= 8'(DEF_FB);
      ref_q   <= REF_W'(DEF_REF);
      pd1_q   <= PD_W'(DEF_PD1);
      pd2_q   <= PD_W'(DEF_PD2);
      freq_q  <= TGT_W'(DEF_FREQ_KHZ);
    end else begin
      done_q <= 1'b0;
      if (launch) begin
        state_q <= ST_RUN;
        tgt_q   <= target_khz_i;
      end else if (running) begin
        if (c_hit) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          found_q <= 1'b1;
          hi_q    <= c_hi;
          fb_q    <= c_fb;
          ref_q   <= c_ref;
          pd1_q   <= c_pd1;
          pd2_q   <= c_pd2;
          freq_q  <= c_freq;
        end else if (c_last) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          found_q <= 1'b0;
          hi_q    <= 1'b0;
          fb_q    <= 8'(DEF_FB);
          ref_q   <= REF_W'(DEF_REF);
          pd1_q   <= PD_W'(DEF_PD1);
          pd2_q   <= PD_W'(DEF_PD2);
          freq_q  <= TGT_W'(DEF_FREQ_KHZ);
        end
      end
    end
  end

  pll_pack #(.REF_W(REF_W), .PD_W(PD_W)) u_pack (
    .fb_i   (fb_q),
    .ref_i  (ref_q),
    .pd1_i  (pd1_q),
    .pd2_i  (pd2_q),
    .hi_i   (hi_q),
    .image_o(image_o)
  );

  assign busy_o     = running;
  assign done_o     = done_q;
  assign found_o    = found_q;
  assign fbdiv_o    = fb_q;
  assign refdiv_o   = ref_q;
  assign postdiv1_o = pd1_q;
  assign postdiv2_o = pd2_q;
  assign freq_khz_o = freq_q;
  assign high_vco_o = hi_q;
endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        found_o,
  input logic [7:0]  fbdiv_o,
  input logic        high_vco_o,
  input logic [31:0] image_o
);
  p_launch_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  p_keep_running_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o));

  p_fb_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && found_o) |-> (fbdiv_o >= 8'd144 && fbdiv_o <= 8'd235));

  p_ctrl_byte_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    image_o[31:24] == (high_vco_o ? 8'h50 : 8'h40));

  p_default_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !found_o) |-> (image_o == 32'h40A0_0241));

  p_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_no_overlap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && busy_o));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(image_o));
endmodule

bind pll_div_search pll_div_search_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .found_o   (found_o),
  .fbdiv_o   (fbdiv_o),
  .high_vco_o(high_vco_o),
  .image_o   (image_o)
);

// File: tb/sim_pll_div_search.sv
module sim_pll_div_search;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [21:0] target_khz_i = '0;
  logic        busy_o, done_o, found_o, high_vco_o;
  logic [7:0]  fbdiv_o;
  logic [1:0]  refdiv_o;
  logic [2:0]  postdiv1_o, postdiv2_o;
  logic [21:0] freq_khz_o;
  logic [31:0] image_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  pll_div_search u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .target_khz_i(target_khz_i),
    .busy_o(busy_o), .done_o(done_o), .found_o(found_o), .fbdiv_o(fbdiv_o),
    .refdiv_o(refdiv_o), .postdiv1_o(postdiv1_o), .postdiv2_o(postdiv2_o),
    .freq_khz_o(freq_khz_o), .high_vco_o(high_vco_o), .image_o(image_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected result from the requirement arithmetic
  typedef struct {
    int  lat; bit fnd; longint fb; longint rf; longint p1; longint p2;
    longint fq; bit hi; longint img;
  } exp_t;

  function automatic exp_t model(input longint t);
    exp_t e;
    int idx = 0;
    e.fnd = 0; e.lat = 42; e.fb = 160; e.rf = 2; e.p1 = 5; e.p2 = 2;
    e.fq = 200000; e.hi = 0;
    for (int r = 2; r >= 1; r--)
      for (int a = 7; a >= 2; a--)
        for (int b = 1; b < a; b++) begin
          longint m, f, d;
          idx++;
          m = longint'(r * a * b);
          f = (m * t + 12500) / 25000;
          d = m * t - 25000 * f;
          if (d < 0) d = -d;
          if (!e.fnd && f >= 144 && f <= 235 && d < 10000 * m) begin
            e.fnd = 1; e.lat = idx; e.fb = f; e.rf = r; e.p1 = a; e.p2 = b;
            e.fq = (25000 * f) / m;
            e.hi = (25000 * f) >= (2400000 * longint'(r));
          end
        end
    e.img = ((e.hi ? 64'h50 : 64'h40) << 24) | (e.fb << 16) | (e.rf << 8)
          | ((e.p1 - 1) << 4) | (e.p2 - 1);
    return e;
  endfunction

  task automatic run(input longint t, input bit inject);
    exp_t e = model(t);
    int lat = 0;
    logic [31:0] img_held;
    @(negedge clk_i);
    start_i = 1'b1;
    target_khz_i = 22'(t);
    @(posedge clk_i);
    lat = 0;
    @(negedge clk_i);
    chk(busy_o === 1'b1, "R1 busy after start", longint'(busy_o), 1);
    start_i = inject;
    target_khz_i = inject ? 22'd200000 : 22'(t);
    while (lat < 60) begin
      @(posedge clk_i);
      lat++;
      @(negedge clk_i);
      start_i = 1'b0;
      if (done_o) break;
    end
    chk(lat == e.lat, inject ? "R1 ignored start latency" : "R2 latency", lat, e.lat);
    chk(found_o == e.fnd, e.fnd ? "R4 found" : "R8 not found", found_o, e.fnd);
    chk(fbdiv_o == e.fb, "R3 fbdiv", fbdiv_o, e.fb);
    chk(refdiv_o == e.rf && postdiv1_o == e.p1 && postdiv2_o == e.p2,
        "R2 divider order", {refdiv_o, postdiv1_o, postdiv2_o},
        (e.rf << 6) | (e.p1 << 3) | e.p2);
    chk(freq_khz_o == e.fq, "R5 freq", freq_khz_o, e.fq);
    chk(high_vco_o == e.hi, "R7 high vco", high_vco_o, e.hi);
    chk(image_o == e.img, e.fnd ? "R6 image" : "R8 default image", image_o, e.img);
    chk(busy_o == 1'b0, "R9 busy low at done", busy_o, 0);
    img_held = image_o;
    @(negedge clk_i);
    chk(done_o == 1'b0, "R9 done pulse", done_o, 0);
    chk(image_o == img_held, "R9 hold", image_o, img_held);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(busy_o == 0 && done_o == 0 && found_o == 0, "R10 reset flags",
        {busy_o, done_o, found_o}, 0);
    chk(image_o == 32'h40A0_0241, "R10 reset image", image_o, 32'h40A0_0241);
    chk(freq_khz_o == 200000, "R10 reset freq", freq_khz_o, 200000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run(200000, 0);
    run(0, 0);
    run(1, 0);
    run(42857, 0);
    run(42858, 0);
    run(485000, 0);
    run(2937500, 0);
    run(2937501, 0);
    run(4194303, 0);
    run(650000, 1);
    run(30000, 1);
    for (longint t = 3000; t < 3300000; t += 3001) run(t, 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule